// File: doc/BRIEF.md
# YCbCr to RGB Saturating Converter

This block turns one luma/chroma byte triple (Y, Cb, Cr) back into 8-bit red, green and blue. Each input first has its offset removed. Y loses 16, and each chroma byte loses 128. The difference is held as a sign bit and a 9-bit magnitude. Each term is multiplied by an unsigned fixed-point coefficient with nine fractional bits. The sign of each product is set from the operand's sign and the coefficient's sign.

The signed products are summed in 37-bit two's complement. The sum is brought back to magnitude form, and the integer byte is taken from it. The byte is then clamped: any value of 256 or more gives 255, and any negative value gives 0.

The inputs are captured on a valid strobe. The arithmetic between the input registers and the outputs is combinational, so the result and an output valid appear one clock after the strobe. The outputs hold their value until the next strobe.

Top module: `ycc_rgb_conv`

## Requirements
- R1: During and after synchronous active-low reset, `out_valid` is 0 and `out_r`, `out_g` and `out_b` are all 0. The captured inputs reset to the neutral triple Y=16, Cb=128, Cr=128.
- R2: `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid`=1, and 0 after an edge that sampled `in_valid`=0.
- R3: With dy=Y-16, dcr=Cr-128 and the integer coefficients 596, 817, 416, 200 and 1033 (scaled by 512), red is clamp(floor((596·dy + 817·dcr)/512)).
- R4: Green is clamp(floor((596·dy − 416·dcr − 200·dcb)/512)), where dcb=Cb-128.
- R5: Blue is clamp(floor((596·dy + 1033·dcb)/512)).
- R6: A channel whose integer result is 256 or more, including results of 512 or more, reads 255.
- R7: A channel whose signed sum is negative reads 0.
- R8: While `in_valid` is 0, changes on `in_y`, `in_cb` and `in_cr` leave `out_r`, `out_g` and `out_b` unchanged.
- R9: When the captured Cb and Cr are both 128, the three outputs are equal. Zero chroma products carry a positive sign, so they add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for the input triple |
| in_y | input | 8 | Luma byte |
| in_cb | input | 8 | Blue-difference chroma byte |
| in_cr | input | 8 | Red-difference chroma byte |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_r | output | 8 | Red byte |
| out_g | output | 8 | Green byte |
| out_b | output | 8 | Blue byte |

## Verification
On every cycle, the assertions check the valid timing, holding of the outputs without a strobe, equal channels for neutral chroma, the clamp to 0 for a dark pixel with red-deficient chroma, and the clamp to 255 for a bright pixel with strong red.

Only the bench's sweep can show the exact per-channel arithmetic. It drives every luma value against a grid of chroma values that includes the offset boundaries, and compares each result with a model computed from the integer formulas. Saturation above 511 on blue and the ignored-input behaviour are also checked at the ports by dedicated scenarios.

// File: rtl/ycc_rgb_pkg.sv
// Package: shared widths for the YCbCr to RGB converter.
// Assumes 8-bit components and coefficients with nine fractional bits.
package ycc_rgb_pkg;
    localparam int unsigned IN_W   = 8;             // component byte
    localparam int unsigned EXT_W  = IN_W + 2;      // sign + overflow guard
    localparam int unsigned MAG_W  = IN_W + 1;      // magnitude after offset
    localparam int unsigned CFR_W  = 9;             // coefficient fraction bits
    localparam int unsigned FIX_W  = MAG_W + CFR_W; // 9.9 operand width
    localparam int unsigned PROD_W = 2 * FIX_W;     // product magnitude
    localparam int unsigned ACC_W  = PROD_W + 1;    // signed accumulator
    localparam int unsigned FRAC_W = 2 * CFR_W;     // product fraction bits
endpackage

// File: rtl/ycc_offset_split.sv
// Module: removes a fixed offset from one component byte and returns
// the difference as sign plus magnitude.
// Assumes |byte - OFFSET| < 2**MAG_W, true for offsets 16 and 128.
module ycc_offset_split
    import ycc_rgb_pkg::*;
#(
    parameter int unsigned OFFSET = 128
) (
    input  logic [IN_W-1:0]  comp,
    output logic             neg,
    output logic [MAG_W-1:0] mag
);
    logic [EXT_W-1:0] ext;
    logic [EXT_W-1:0] diff;

    // Widen with zero sign/guard bits, subtract, fold to magnitude.
    always_comb begin
        ext  = {2'b00, comp};
        diff = ext - EXT_W'(OFFSET);
        neg  = diff[EXT_W-1];
        mag  = neg ? (~diff[MAG_W-1:0] + MAG_W'(1)) : diff[MAG_W-1:0];
    end
endmodule

// File: rtl/ycc_signed_product.sv
// Module: multiplies a sign/magnitude operand by a constant coefficient
// magnitude and returns a two's-complement term for accumulation.
// Assumes COEF fits FIX_W bits with CFR_W fraction bits; CNEG marks a
// negative coefficient. A zero product always carries a positive sign.
module ycc_signed_product
    import ycc_rgb_pkg::*;
#(
    parameter int unsigned COEF = 596,
    parameter bit          CNEG = 1'b0
) (
    input  logic             op_neg,
    input  logic [MAG_W-1:0] op_mag,
    output logic [ACC_W-1:0] term
);
    logic [FIX_W-1:0]  op_fix;
    logic [PROD_W-1:0] prod;
    logic              p_neg;
    logic [ACC_W-1:0]  ext;

    // Multiply magnitudes, derive the sign, convert to two's complement.
    always_comb begin
        op_fix = {op_mag, {CFR_W{1'b0}}};
        prod   = PROD_W'(op_fix) * PROD_W'(FIX_W'(COEF));
        p_neg  = (op_neg ^ CNEG) & (|prod);
        ext    = {1'b0, prod};
        term   = p_neg ? (~ext + ACC_W'(1)) : ext;
    end
endmodule

// File: rtl/ycc_clamp_sum.sv
// Module: sums N two's-complement terms, takes the integer byte of the
// magnitude and clamps it to 0..255.
// Assumes the true sum fits ACC_W bits, so the addition cannot wrap.
module ycc_clamp_sum
    import ycc_rgb_pkg::*;
#(
    parameter int unsigned N_TERMS = 2
) (
    input  logic [N_TERMS-1:0][ACC_W-1:0] terms,
    output logic [IN_W-1:0]               pix
);
    localparam int unsigned HI_W = ACC_W - 1 - FRAC_W;

    logic [ACC_W-1:0] acc;
    logic             s_neg;
    logic             lo_zero;
    logic [HI_W-1:0]  hi_mag;
    logic             ovf;

    // Accumulate the signed terms.
    always_comb begin
        acc = '0;
        for (int i = 0; i < N_TERMS; i++) begin
            acc = acc + terms[i];
        end
    end

    // Integer part of |acc|: negate only the upper part, carry in when
    // the fraction is zero; then OR in overflow, AND with inverted sign.
    always_comb begin
        s_neg   = acc[ACC_W-1];
        lo_zero = (acc[FRAC_W-1:0] == '0);
        hi_mag  = s_neg ? (~acc[ACC_W-2:FRAC_W] + HI_W'(lo_zero))
                        : acc[ACC_W-2:FRAC_W];
        ovf     = |hi_mag[HI_W-1:IN_W];
        pix     = (hi_mag[IN_W-1:0] | {IN_W{ovf}}) & {IN_W{~s_neg}};
    end
endmodule

// File: rtl/ycc_rgb_conv.sv
// Module: YCbCr to RGB converter top. Captures a triple on in_valid;
// the combinational core drives the outputs, valid one cycle later.
// Assumes a synchronous active-low reset; outputs hold between strobes.
module ycc_rgb_conv
    import ycc_rgb_pkg::*;
#(
    parameter int unsigned Y_OFS   = 16,
    parameter int unsigned C_OFS   = 128,
    parameter int unsigned K_Y     = 596,   // 1.164 * 512
    parameter int unsigned K_R_CR  = 817,   // 1.596 * 512
    parameter int unsigned K_G_CR  = 416,   // 0.813 * 512
    parameter int unsigned K_G_CB  = 200,   // 0.391 * 512
    parameter int unsigned K_B_CB  = 1033   // 2.018 * 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_y,
    input  logic [IN_W-1:0] in_cb,
    input  logic [IN_W-1:0] in_cr,
    output logic            out_valid,
    output logic [IN_W-1:0] out_r,
    output logic [IN_W-1:0] out_g,
    output logic [IN_W-1:0] out_b
);
    logic [IN_W-1:0] y_q, cb_q, cr_q;
    logic            v_q;

    // Capture the triple on a strobe; reset to the neutral black triple.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q  <= IN_W'(Y_OFS);
            cb_q <= IN_W'(C_OFS);
            cr_q <= IN_W'(C_OFS);
        end else if (in_valid) begin
            y_q  <= in_y;
            cb_q <= in_cb;
            cr_q <= in_cr;
        end
    end

    // Output valid follows the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= in_valid;
    end

    logic             y_neg, cb_neg, cr_neg;
    logic [MAG_W-1:0] y_mag, cb_mag, cr_mag;

    ycc_offset_split #(.OFFSET(Y_OFS)) u_off_y (.comp(y_q),  .neg(y_neg),  .mag(y_mag));
    ycc_offset_split #(.OFFSET(C_OFS)) u_off_cb(.comp(cb_q), .neg(cb_neg), .mag(cb_mag));
    ycc_offset_split #(.OFFSET(C_OFS)) u_off_cr(.comp(cr_q), .neg(cr_neg), .mag(cr_mag));

    logic [ACC_W-1:0] t_y, t_r_cr, t_g_cr, t_g_cb, t_b_cb;

    ycc_signed_product #(.COEF(K_Y),    .CNEG(1'b0)) u_p_y   (.op_neg(y_neg),  .op_mag(y_mag),  .term(t_y));
    ycc_signed_product #(.COEF(K_R_CR), .CNEG(1'b0)) u_p_rcr (.op_neg(cr_neg), .op_mag(cr_mag), .term(t_r_cr));
    ycc_signed_product #(.COEF(K_G_CR), .CNEG(1'b1)) u_p_gcr (.op_neg(cr_neg), .op_mag(cr_mag), .term(t_g_cr));
    ycc_signed_product #(.COEF(K_G_CB), .CNEG(1'b1)) u_p_gcb (.op_neg(cb_neg), .op_mag(cb_mag), .term(t_g_cb));
    ycc_signed_product #(.COEF(K_B_CB), .CNEG(1'b0)) u_p_bcb (.op_neg(cb_neg), .op_mag(cb_mag), .term(t_b_cb));

    ycc_clamp_sum #(.N_TERMS(2)) u_sum_r (.terms({t_r_cr, t_y}),         .pix(out_r));
    ycc_clamp_sum #(.N_TERMS(3)) u_sum_g (.terms({t_g_cb, t_g_cr, t_y}), .pix(out_g));
    ycc_clamp_sum #(.N_TERMS(2)) u_sum_b (.terms({t_b_cb, t_y}),         .pix(out_b));

    assign out_valid = v_q;

    // R2: valid follows a sampled strobe.
    p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8: no strobe, no change at the outputs.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
    // R9: neutral chroma gives equal channels.
    p_grey_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_q == 8'd128 && cr_q == 8'd128) |-> (out_r == out_g && out_g == out_b));
    // R7: black luma with red-deficient chroma clamps red to zero.
    p_neg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (y_q <= 8'd16 && cr_q <= 8'd128) |-> (out_r == 8'd0));
    // R6: bright luma with strong red saturates red.
    p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (y_q >= 8'd235 && cr_q >= 8'd192) |-> (out_r == 8'hFF));
endmodule

// File: tb/ycc_rgb_conv_bench.sv
// Bench: sweeps every luma value against a chroma grid and compares
// with integer formulas; adds reset, timing, clamp and hold scenarios.
module ycc_rgb_conv_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_y = 8'd0, in_cb = 8'd0, in_cr = 8'd0;
    logic       out_valid;
    logic [7:0] out_r, out_g, out_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ycc_rgb_conv u_ycc_rgb_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic int clampv(int s);
        if (s < 0) return 0;
        if ((s / 512) > 255) return 255;
        return s / 512;
    endfunction

    function automatic int exp_r(int y, int cb, int cr);
        return clampv(596 * (y - 16) + 817 * (cr - 128));
    endfunction
    function automatic int exp_g(int y, int cb, int cr);
        return clampv(596 * (y - 16) - 416 * (cr - 128) - 200 * (cb - 128));
    endfunction
    function automatic int exp_b(int y, int cb, int cr);
        return clampv(596 * (y - 16) + 1033 * (cb - 128));
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe one triple, then sample one cycle later away from the edge.
    task automatic apply(int y, int cb, int cr);
        @(negedge clk);
        in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    int grid [9] = '{0, 1, 51, 100, 127, 128, 129, 200, 255};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(out_valid), 0);
        check("R1 red",   int'(out_r), 0);
        check("R1 green", int'(out_g), 0);
        check("R1 blue",  int'(out_b), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(out_r) + int'(out_g) + int'(out_b), 0);

        // R2: valid one cycle after strobe, then low
        apply(100, 90, 180);
        check("R2 valid high", int'(out_valid), 1);
        @(negedge clk);
        check("R2 valid low", int'(out_valid), 0);

        // R8: inputs ignored without strobe
        in_y = 8'd255; in_cb = 8'd0; in_cr = 8'd255;
        @(negedge clk);
        @(negedge clk);
        check("R8 red held",   int'(out_r), exp_r(100, 90, 180));
        check("R8 green held", int'(out_g), exp_g(100, 90, 180));
        check("R8 blue held",  int'(out_b), exp_b(100, 90, 180));

        // R6: blue sum exceeds 511, red above 255
        apply(255, 255, 255);
        check("R6 blue sat", int'(out_b), 255);
        check("R6 red sat",  int'(out_r), 255);
        // R7: negative sums clamp to zero
        apply(0, 0, 0);
        check("R7 red zero",  int'(out_r), 0);
        check("R7 blue zero", int'(out_b), 0);
        apply(16, 255, 255);
        check("R7 green zero", int'(out_g), 0);
        // R9: neutral chroma gives equal channels
        apply(200, 128, 128);
        check("R9 r==g", int'(out_r), int'(out_g));
        check("R9 g==b", int'(out_g), int'(out_b));
        check("R9 value", int'(out_r), (596 * 184) / 512);

        // R3 R4 R5: sweep all luma against the chroma grid
        for (int y = 0; y < 256; y++) begin
            for (int i = 0; i < 9; i++) begin
                for (int j = 0; j < 9; j++) begin
                    apply(y, grid[i], grid[j]);
                    check("R3 red",   int'(out_r), exp_r(y, grid[i], grid[j]));
                    check("R4 green", int'(out_g), exp_g(y, grid[i], grid[j]));
                    check("R5 blue",  int'(out_b), exp_b(y, grid[i], grid[j]));
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule